// File: doc/BRIEF.md
# Per-Processor Device Interrupt Router

The block gathers up to 64 device interrupt lines into one shared raw request word and hands each of four processors its own filtered view of that word. Every processor owns a 64-bit enable mask. The view each processor sees is always the bitwise AND of its mask and the raw request word. A processor's level interrupt output is high while its view has any bit set.

Devices drive a set pulse or a clear pulse together with an interrupt number. Software reaches the masks, the four filtered views and the raw word through a register port. Every register sits in its own 64-byte slot, and only full 64-bit accesses are accepted. The masks are read/write. The views and the raw word are read-only. An illegal access raises a one-cycle error pulse and changes nothing. A clear aimed at a line that is not active raises a one-cycle spurious pulse.

Top module: `dev_irq_router`

## Requirements
- R1: After reset, all masks, the raw word, `cpu_irq`, `reg_err`, `spurious` and `reg_rdata` are zero.
- R2: A `dev_set` pulse with number n sets raw bit n. A read of offset 8 at byte address BASE+0x200 returns the raw word.
- R3: A `dev_clr` pulse with number n clears raw bit n when that bit is set. When the bit is clear, the raw word is unchanged and `spurious` is high in the next cycle.
- R4: When `dev_set` and `dev_clr` are asserted in the same cycle, the set wins: bit n ends up set and `spurious` stays low.
- R5: A 64-bit write to offset c, at byte address BASE+64*c for c = 0..3, stores the full data word as the mask of processor c. A read of the same offset returns it.
- R6: A read of offset 4+c returns the mask of processor c ANDed with the raw word.
- R7: `cpu_irq[c]` is high exactly when the filtered view of processor c is nonzero. It follows a state change one clock later than `reg_rdata` would.
- R8: A write to offsets 4 through 8 changes no state and pulses `reg_err` in the next cycle.
- R9: An access with `reg_size` other than 3 pulses `reg_err`, changes no state and returns zero read data. The size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit.
- R10: An access to an offset above 8 pulses `reg_err`, and a read there returns zero. Legal accesses leave `reg_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_set | input | 1 | Device request pulse for line `dev_num` |
| dev_clr | input | 1 | Device withdraw pulse for line `dev_num` |
| dev_num | input | 6 | Interrupt number |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 16 | Byte address |
| reg_size | input | 2 | Access size code |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the strobe |
| reg_err | output | 1 | Illegal access pulse |
| spurious | output | 1 | Clear of an inactive line pulse |
| cpu_irq | output | 4 | Level interrupt per processor |

## Verification
Read data, `reg_err` and `spurious` are registered on the same edge that takes the stimulus. They are sampled shortly after that edge, and they reflect the state before the update. `cpu_irq` reflects the updated state only after a second edge. Every operation therefore checks `cpu_irq` twice: after the first edge against the model's old value, and after the second edge against its new value. Random device events, mask writes and reads are mixed with directed cases for set/clear collisions, spurious clears, read-only writes, narrow sizes and unmapped offsets.

// File: rtl/dev_irq_router.sv
module dev_irq_router #(
  parameter int NCPU = 4,
  parameter int NIRQ = 64,
  parameter int AW = 16,
  parameter logic [15:0] BASE = 16'h1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dev_set,
  input  logic            dev_clr,
  input  logic [$clog2(NIRQ)-1:0] dev_num,
  input  logic            reg_en,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [1:0]      reg_size,
  input  logic [NIRQ-1:0] reg_wdata,
  output logic [NIRQ-1:0] reg_rdata,
  output logic            reg_err,
  output logic            spurious,
  output logic [NCPU-1:0] cpu_irq
);
  localparam int OW = AW - 6;
  localparam logic [OW-1:0] RES_LO = OW'(NCPU);
  localparam logic [OW-1:0] RAW_OFS = OW'(2 * NCPU);

  logic [NIRQ-1:0] mask [NCPU];
  logic [NIRQ-1:0] raw;
  logic [NIRQ-1:0] rd_val;

  wire [AW-1:0] rel = reg_addr - AW'(BASE);
  wire [OW-1:0] ofs = rel[AW-1:6];
  wire full      = reg_size == 2'd3;
  wire hit_mask  = ofs < RES_LO;
  wire hit_ro    = (ofs >= RES_LO) && (ofs <= RAW_OFS);
  wire acc_ok    = reg_en && full && (hit_mask || (hit_ro && !reg_we));
  wire wr_mask   = acc_ok && reg_we;
  wire rd_ok     = acc_ok && !reg_we;

  wire [NIRQ-1:0] one  = {{(NIRQ-1){1'b0}}, 1'b1};
  wire [NIRQ-1:0] setv = dev_set ? (one << dev_num) : '0;
  wire [NIRQ-1:0] clrv = dev_clr ? (one << dev_num) : '0;
  wire spur_nxt = dev_clr && !dev_set && !raw[dev_num];

  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (ofs == OW'(c)) rd_val = mask[c];
      if (ofs == OW'(c + NCPU)) rd_val = mask[c] & raw;
    end
    if (ofs == RAW_OFS) rd_val = raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw <= '0;
      reg_rdata <= '0;
      reg_err <= 1'b0;
      spurious <= 1'b0;
    end else begin
      raw <= (raw & ~clrv) | setv;
      reg_rdata <= rd_ok ? rd_val : '0;
      reg_err <= reg_en && !acc_ok;
      spurious <= spur_nxt;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask[c] <= '0;
        cpu_irq[c] <= 1'b0;
      end else begin
        if (wr_mask && ofs == OW'(c)) mask[c] <= reg_wdata;
        cpu_irq[c] <= |(mask[c] & raw);
      end
    end

    // R7
    mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_en && reg_we && full && rel[AW-1:6] == OW'(c) && reg_wdata == '0) |=> ##1 !cpu_irq[c]);
  end

  // R3
  spurious_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |-> $past(dev_clr && !dev_set));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_set && dev_clr) |=> (raw[$past(dev_num)] && !spurious));

  // R8
  ro_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && full && hit_ro && !dev_set && !dev_clr) |=> ($stable(raw) && reg_err));

  // R9
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_size != 2'd3) |=> (reg_err && reg_rdata == '0));
endmodule

// File: tb/tb_dev_irq_router.sv
`timescale 1ns/1ps
module tb_dev_irq_router;
  logic clk = 0, rst_n = 0;
  logic dev_set = 0, dev_clr = 0;
  logic [5:0] dev_num = 0;
  logic reg_en = 0, reg_we = 0;
  logic [15:0] reg_addr = 0;
  logic [1:0] reg_size = 0;
  logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata;
  logic reg_err, spurious;
  logic [3:0] cpu_irq;

  int errors = 0, checks = 0;
  logic [63:0] m_mask [4];
  logic [63:0] m_raw;

  dev_irq_router dut (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] m_irq();
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = |(m_mask[c] & m_raw);
    return r;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic op(bit s, bit k, logic [5:0] n, bit en, bit we,
                    logic [15:0] a, logic [1:0] sz, logic [63:0] d, string tag);
    logic [15:0] rel;
    logic [9:0] ofs;
    logic legal;
    logic [63:0] erd;
    logic [3:0] pre;
    rel = a - 16'h1000;
    ofs = rel[15:6];
    legal = en && sz == 2'd3 && (ofs < 4 || (ofs <= 8 && !we));
    erd = 0;
    if (legal && !we) begin
      if (ofs < 4) erd = m_mask[ofs[1:0]];
      else if (ofs < 8) erd = m_mask[ofs[1:0]] & m_raw;
      else erd = m_raw;
    end
    pre = m_irq();
    dev_set = s; dev_clr = k; dev_num = n;
    reg_en = en; reg_we = we; reg_addr = a; reg_size = sz; reg_wdata = d;
    tick();
    dev_set = 0; dev_clr = 0; reg_en = 0; reg_we = 0;
    chk({tag, " R2 R5 R6 rdata"}, reg_rdata, erd);
    chk({tag, " R8 R9 R10 err"}, 64'(reg_err), 64'(en && !legal));
    chk({tag, " R3 R4 spurious"}, 64'(spurious), 64'(k && !s && !m_raw[n]));
    chk({tag, " R7 irq lag"}, 64'(cpu_irq), 64'(pre));
    if (legal && we) m_mask[ofs[1:0]] = d;
    if (k) m_raw[n] = 1'b0;
    if (s) m_raw[n] = 1'b1;
    tick();
    chk({tag, " R7 irq"}, 64'(cpu_irq), 64'(m_irq()));
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    for (int c = 0; c < 4; c++) m_mask[c] = 0;
    m_raw = 0;
    tick(); tick();
    rst_n = 1;
    #0.5;
    chk("R1 irq", 64'(cpu_irq), 0);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 err", 64'(reg_err), 0);
    chk("R1 spurious", 64'(spurious), 0);
    op(0, 0, 0, 1, 0, 16'h1200, 3, 0, "R1 raw read");
    op(0, 0, 0, 1, 0, 16'h1040, 3, 0, "R1 mask read");
    op(1, 0, 6'd63, 0, 0, 0, 0, 0, "R2 set63");
    op(0, 0, 0, 1, 0, 16'h1200, 3, 0, "R2 raw");
    op(0, 1, 6'd5, 0, 0, 0, 0, 0, "R3 spurious clr");
    op(1, 1, 6'd5, 0, 0, 0, 0, 0, "R4 collide");
    op(0, 0, 0, 1, 0, 16'h1200, 3, 0, "R4 raw");
    op(0, 0, 0, 1, 1, 16'h1080, 3, 64'h8000_0000_0000_0020, "R5 mask2");
    op(0, 0, 0, 1, 0, 16'h1080, 3, 0, "R5 readback");
    op(0, 0, 0, 1, 0, 16'h1180, 3, 0, "R6 view2");
    op(0, 1, 6'd5, 0, 0, 0, 0, 0, "R3 clr5");
    op(0, 0, 0, 1, 1, 16'h1200, 3, 64'hFFFF, "R8 raw write");
    op(0, 0, 0, 1, 1, 16'h1100, 3, 64'hFFFF, "R8 view write");
    op(0, 0, 0, 1, 0, 16'h1200, 3, 0, "R8 raw after");
    op(0, 0, 0, 1, 1, 16'h1000, 2, 64'hFFFF, "R9 narrow write");
    op(0, 0, 0, 1, 0, 16'h1000, 0, 0, "R9 narrow read");
    op(0, 0, 0, 1, 0, 16'h1000, 3, 0, "R9 mask0 after");
    op(0, 0, 0, 1, 0, 16'h1240, 3, 0, "R10 unmapped");
    op(0, 0, 0, 1, 0, 16'h0FC0, 3, 0, "R10 below base");
    op(0, 0, 0, 1, 1, 16'h1080, 3, 0, "R7 mask off");
    for (int i = 0; i < 400; i++) begin
      int t;
      logic [5:0] n;
      logic [15:0] a;
      t = int'($urandom_range(0, 9));
      n = 6'($urandom_range(0, 63));
      a = 16'h1000 + 16'($urandom_range(0, 9) * 64);
      case (t)
        0, 1: op(1, 0, n, 0, 0, 0, 0, 0, "rnd set R2");
        2, 3: op(0, 1, n, 0, 0, 0, 0, 0, "rnd clr R3");
        4: op(1, 1, n, 0, 0, 0, 0, 0, "rnd both R4");
        5: op(0, 0, 0, 1, 1, 16'h1000 + 16'($urandom_range(0, 3) * 64), 3,
              {$urandom, $urandom} & {$urandom, $urandom}, "rnd mask R5");
        6, 7: op(0, 0, 0, 1, 0, a, 3, 0, "rnd read R6");
        8: op(0, 0, 0, 1, $urandom_range(0, 1) == 1, a, 2'($urandom_range(0, 3)),
              {$urandom, $urandom}, "rnd any R9");
        default: op($urandom_range(0, 1) == 1, 0, n, 1, 0, a, 3, 0, "rnd mix R7");
      endcase
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule